// File: doc/BRIEF.md
# Replaying Transmit and Command Queue

This block is the queue that sits between a host and the shift engine of a serial bus master. The host pushes words into it, and a one-bit tag on each word marks it as either a command or a data word. The engine reads the oldest entry from the head and removes it with a pop strobe.

The block also decides two things for the engine:

- **Frame end.** A frame closes when the configured number of bits has been shifted. It also closes at a word boundary when the next entry waiting at the head is a command.
- **Start permission.** A new transfer may begin only when the block is enabled, an entry is waiting, and the hardware request is present. The request is latched once, when the engine next goes idle. A gate input can bypass the request.

Loop mode lets the engine repeat a short stored sequence with no further host writes. When loop mode is switched on, the read position is saved. The host-facing status then stops moving. Each time the queue drains while the engine is idle, the read position is reloaded from the saved copy. The entries are therefore replayed instead of being used up.

Top module: `txq_loop_fifo`

## Requirements
- R1: Entries leave the head in the order they were written, each with its tag (`head_cmd` = 1 for a command word, 0 for a data word). `head_valid` is high whenever the queue holds an entry, and each `pop` removes the head entry.
- R2: `q_count`, `q_empty`, `q_full` and `q_low` are registered. They show the occupancy one clock after a write or pop takes effect. `q_low` is high when the count is at most LOW_MARK (default 1), and `q_full` is high when the count equals 2**AW (default 4).
- R3: A write while the queue is full is dropped and sets `q_ovf`, which stays high until reset. A pop while the queue is empty has no effect.
- R4: On the first clock on which `loop_en` is high, the current read position is saved.
- R5: On every clock on which `loop_en` is high, the four status outputs keep their values, even while entries are popped or written.
- R6: When loop mode has been on since the previous clock, the queue appears drained and `eng_idle` is high, the read position is reloaded from the saved copy. The first saved entry is back at the head on the next clock. While the engine is busy, no reload happens.
- R7: In loop mode, fullness is judged against the saved read position. Writes are accepted only while they would not overwrite an entry that is still due for replay.
- R8: When `loop_en` falls, reading continues from the current read position without a reload, and the status outputs are recomputed at the next clock.
- R9: Each `word_done` pulse adds DW (8) bits to a frame total. If the new total reaches `frame_bits`, `frame_end` pulses one clock later and the total clears.
- R10: A `word_done` pulse while a command word is at the head also pulses `frame_end` one clock later and clears the total, whatever the count.
- R11: `hreq` is latched only on the first idle clock after a busy period (or after reset). Changes to `hreq` at any other time do not affect `start_ok`.
- R12: `start_ok` is registered. It is high one clock after `blk_en`, an entry at the head, and either a latched request or `hreq_gate` low, are all present together.
- R13: After reset the queue is empty (`q_empty` = 1, `q_count` = 0, `head_valid` = 0), and `q_ovf`, `frame_end` and `start_ok` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Block enable for transfer start |
| wr_en | input | 1 | Host write strobe |
| wr_cmd | input | 1 | Tag of the written word: 1 command, 0 data |
| wr_data | input | DW | Written word |
| pop | input | 1 | Engine removes the head entry |
| head_data | output | DW | Word at the head |
| head_cmd | output | 1 | Tag of the head word |
| head_valid | output | 1 | Head holds an entry |
| loop_en | input | 1 | Loop (replay) mode enable |
| eng_idle | input | 1 | Shift engine is idle |
| word_done | input | 1 | Engine finished shifting one word |
| frame_bits | input | FBW | Frame length in bits |
| hreq | input | 1 | Hardware request |
| hreq_gate | input | 1 | 1: start requires the latched request |
| q_count | output | AW+1 | Registered occupancy |
| q_empty | output | 1 | Registered empty flag |
| q_full | output | 1 | Registered full flag |
| q_low | output | 1 | Registered low-level flag |
| q_ovf | output | 1 | Sticky overflow flag |
| frame_end | output | 1 | One-clock frame end pulse |
| start_ok | output | 1 | Transfer may start |

## Verification
The bench pops a loop sequence dry while the engine is busy and confirms that no reload happens until idle, and that the status stays frozen throughout. A design that reloads early or lets status move would show the wrong head or a shrinking count.

It advances the read position in loop mode and then writes two more words. If fullness were taken from the live read position, the second write would overwrite the first saved entry, and the replay would start with the wrong word.

It ends a frame early with a command at the head, then counts a full frame again, which exposes a bit total that is not cleared. It also moves `hreq` while the engine stays idle; a latch that samples continuously would wrongly raise `start_ok`.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef logic tag_t;
  localparam tag_t TAG_DATA = 1'b0;
  localparam tag_t TAG_CMD  = 1'b1;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW:0]   wword,
  input  logic [AW-1:0] raddr,
  output logic [DW:0]   rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/txq_ptr_ctrl.sv
module txq_ptr_ctrl #(
  parameter int AW = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_req,
  input  logic        pop,
  input  logic        loop_en,
  input  logic        eng_idle,
  output logic [AW:0] wr_ptr,
  output logic [AW:0] rd_ptr,
  output logic        wr_ok,
  output logic        empty_raw,
  output logic        ovf
);
  localparam logic [AW:0] FULL_OCC = {1'b1, {AW{1'b0}}};

  logic        loop_q;
  logic [AW:0] shadow;
  logic [AW:0] base;
  logic [AW:0] occ_base;
  logic        full_raw;
  logic        restore;
  logic        rd_step;

  assign base      = loop_q ? shadow : rd_ptr;
  assign occ_base  = wr_ptr - base;
  assign full_raw  = (occ_base == FULL_OCC);
  assign empty_raw = (wr_ptr == rd_ptr);
  assign wr_ok     = wr_req && !full_raw;
  assign restore   = loop_en && loop_q && empty_raw && eng_idle;
  assign rd_step   = pop && !empty_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      shadow <= '0;
      loop_q <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      loop_q <= loop_en;
      if (loop_en && !loop_q) shadow <= rd_ptr;
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (wr_req && full_raw) ovf <= 1'b1;
      if (restore) rd_ptr <= shadow;
      else if (rd_step) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - base) <= FULL_OCC); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R3
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && empty_raw && !restore) |=> $stable(rd_ptr)); // R3
endmodule

// File: rtl/txq_status.sv
module txq_status #(
  parameter int AW       = 2,
  parameter int LOW_MARK = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        loop_en,
  input  logic [AW:0] wr_ptr,
  input  logic [AW:0] rd_ptr,
  output logic [AW:0] count,
  output logic        empty,
  output logic        full,
  output logic        low
);
  localparam logic [AW:0] FULL_OCC = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] LOW_LVL  = (AW+1)'(LOW_MARK);

  logic [AW:0] occ;
  assign occ = wr_ptr - rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
      low   <= 1'b1;
    end else if (!loop_en) begin
      count <= occ;
      empty <= (occ == '0);
      full  <= (occ == FULL_OCC);
      low   <= (occ <= LOW_LVL);
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R2
  AST_EMPTY_COUNT: assert property (@(posedge clk) disable iff (rst)
    empty |-> (count == '0)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> $stable(count)); // R5
endmodule

// File: rtl/txq_frame_gate.sv
module txq_frame_gate #(
  parameter int DW  = 8,
  parameter int FBW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           word_done,
  input  logic           head_valid,
  input  logic           head_cmd,
  input  logic [FBW-1:0] frame_bits,
  input  logic           eng_idle,
  input  logic           hreq,
  input  logic           hreq_gate,
  input  logic           blk_en,
  output logic           frame_end,
  output logic           start_ok
);
  localparam logic [FBW:0] STEP = (FBW+1)'(DW);

  logic [FBW-1:0] acc;
  logic [FBW:0]   acc_sum;
  logic           reach;
  logic           cmd_next;
  logic           idle_q;
  logic           req_lat;

  assign acc_sum  = {1'b0, acc} + STEP;
  assign reach    = acc_sum >= {1'b0, frame_bits};
  assign cmd_next = head_valid && head_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      frame_end <= 1'b0;
      idle_q    <= 1'b0;
      req_lat   <= 1'b0;
      start_ok  <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (word_done) begin
        if (reach || cmd_next) begin
          frame_end <= 1'b1;
          acc       <= '0;
        end else begin
          acc <= acc_sum[FBW-1:0];
        end
      end
      idle_q <= eng_idle;
      if (eng_idle && !idle_q) req_lat <= hreq;
      start_ok <= blk_en && (!hreq_gate || req_lat) && head_valid;
    end
  end

  AST_FRAME_SRC: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $past(word_done)); // R9
  AST_START_QUAL: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> ($past(blk_en) && $past(head_valid))); // R12
endmodule

// File: rtl/txq_loop_fifo.sv
module txq_loop_fifo #(
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int FBW      = 8,
  parameter int LOW_MARK = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           blk_en,
  input  logic           wr_en,
  input  logic           wr_cmd,
  input  logic [DW-1:0]  wr_data,
  input  logic           pop,
  output logic [DW-1:0]  head_data,
  output logic           head_cmd,
  output logic           head_valid,
  input  logic           loop_en,
  input  logic           eng_idle,
  input  logic           word_done,
  input  logic [FBW-1:0] frame_bits,
  input  logic           hreq,
  input  logic           hreq_gate,
  output logic [AW:0]    q_count,
  output logic           q_empty,
  output logic           q_full,
  output logic           q_low,
  output logic           q_ovf,
  output logic           frame_end,
  output logic           start_ok
);
  import txq_pkg::*;

  logic [AW:0] wr_ptr;
  logic [AW:0] rd_ptr;
  logic        wr_ok;
  logic        empty_raw;
  logic [DW:0] rd_word;
  tag_t        wr_tag;

  assign wr_tag = wr_cmd ? TAG_CMD : TAG_DATA;

  txq_ptr_ctrl #(.AW(AW)) ptr_i (
    .clk(clk), .rst(rst), .wr_req(wr_en), .pop(pop), .loop_en(loop_en),
    .eng_idle(eng_idle), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_ok(wr_ok),
    .empty_raw(empty_raw), .ovf(q_ovf)
  );

  txq_store #(.DW(DW), .AW(AW)) store_i (
    .clk(clk), .we(wr_ok), .waddr(wr_ptr[AW-1:0]), .wword({wr_tag, wr_data}),
    .raddr(rd_ptr[AW-1:0]), .rword(rd_word)
  );

  txq_status #(.AW(AW), .LOW_MARK(LOW_MARK)) stat_i (
    .clk(clk), .rst(rst), .loop_en(loop_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(q_count), .empty(q_empty), .full(q_full), .low(q_low)
  );

  assign head_valid = !empty_raw;
  assign head_data  = rd_word[DW-1:0];
  assign head_cmd   = (rd_word[DW] == TAG_CMD);

  txq_frame_gate #(.DW(DW), .FBW(FBW)) gate_i (
    .clk(clk), .rst(rst), .word_done(word_done), .head_valid(head_valid),
    .head_cmd(head_cmd), .frame_bits(frame_bits), .eng_idle(eng_idle),
    .hreq(hreq), .hreq_gate(hreq_gate), .blk_en(blk_en),
    .frame_end(frame_end), .start_ok(start_ok)
  );

  AST_HEAD_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!loop_en && $past(!loop_en) && !head_valid && $past(!head_valid) && !wr_en) |=> q_empty); // R2
endmodule

// File: tb/txq_loop_fifo_tb.sv
`timescale 1ns/1ps
module txq_loop_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst, blk_en, wr_en, wr_cmd, pop, loop_en, eng_idle, word_done;
  logic       hreq, hreq_gate;
  logic [7:0] wr_data, frame_bits;
  logic [7:0] head_data;
  logic       head_cmd, head_valid;
  logic [2:0] q_count;
  logic       q_empty, q_full, q_low, q_ovf, frame_end, start_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  txq_loop_fifo dut_i (
    .clk(clk), .rst(rst), .blk_en(blk_en), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_data(wr_data), .pop(pop), .head_data(head_data), .head_cmd(head_cmd),
    .head_valid(head_valid), .loop_en(loop_en), .eng_idle(eng_idle),
    .word_done(word_done), .frame_bits(frame_bits), .hreq(hreq),
    .hreq_gate(hreq_gate), .q_count(q_count), .q_empty(q_empty),
    .q_full(q_full), .q_low(q_low), .q_ovf(q_ovf), .frame_end(frame_end),
    .start_ok(start_ok)
  );

  // [23] op 1=pop, [22] cmd, [21:14] data, [13:11] count, [10] head_valid,
  // [9] head_cmd, [8:1] head_data, [0] low
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 1'b1, 8'hA1, 3'd1, 1'b1, 1'b1, 8'hA1, 1'b1},
    {1'b0, 1'b0, 8'h11, 3'd2, 1'b1, 1'b1, 8'hA1, 1'b0},
    {1'b0, 1'b0, 8'h22, 3'd3, 1'b1, 1'b1, 8'hA1, 1'b0},
    {1'b1, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b0, 1'b0, 8'h33, 3'd3, 1'b1, 1'b0, 8'h11, 1'b0},
    {1'b1, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 8'h22, 1'b0},
    {1'b1, 1'b0, 8'h00, 3'd1, 1'b1, 1'b0, 8'h33, 1'b1},
    {1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic c, input logic [7:0] d);
    wr_en = 1'b1; wr_cmd = c; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_cmd = 1'b0;
  endtask

  task automatic popw();
    pop = 1'b1;
    cyc(1);
    pop = 1'b0;
  endtask

  task automatic wd();
    word_done = 1'b1;
    cyc(1);
    word_done = 1'b0;
  endtask

  initial begin
    logic [23:0] v;
    rst = 1'b1; blk_en = 1'b1; wr_en = 1'b0; wr_cmd = 1'b0; wr_data = '0;
    pop = 1'b0; loop_en = 1'b0; eng_idle = 1'b1; word_done = 1'b0;
    frame_bits = 8'd24; hreq = 1'b0; hreq_gate = 1'b0;
    cyc(3);
    // R13 reset state
    chk("R13 q_empty", q_empty, 1);
    chk("R13 q_count", q_count, 0);
    chk("R13 head_valid", head_valid, 0);
    chk("R13 q_ovf", q_ovf, 0);
    chk("R13 frame_end", frame_end, 0);
    chk("R13 start_ok", start_ok, 0);
    rst = 1'b0;
    cyc(1);

    // R1 / R2 table walk
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      if (v[23]) popw(); else push(v[22], v[21:14]);
      cyc(1);
      chk("R2 count", q_count, v[13:11]);
      chk("R2 low", q_low, v[0]);
      chk("R1 head_valid", head_valid, v[10]);
      if (v[10]) begin
        chk("R1 head_cmd", head_cmd, v[9]);
        chk("R1 head_data", head_data, v[8:1]);
      end
    end

    // R2 / R3 full and overflow
    for (int i = 0; i < 4; i++) push(1'b0, 8'h40 + 8'(i));
    cyc(1);
    chk("R2 full", q_full, 1);
    chk("R2 count full", q_count, 4);
    push(1'b0, 8'h99);
    chk("R3 ovf set", q_ovf, 1);
    cyc(1);
    chk("R3 count after drop", q_count, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 order after drop", head_data, 8'h40 + 8'(i));
      popw();
    end
    chk("R3 drained", head_valid, 0);
    popw();
    push(1'b0, 8'h55);
    chk("R3 pop on empty ignored head", head_data, 8'h55);
    cyc(1);
    chk("R3 pop on empty ignored count", q_count, 1);
    chk("R3 ovf sticky", q_ovf, 1);
    popw();

    // R4 / R5 / R6 loop replay
    eng_idle = 1'b0;
    push(1'b1, 8'hC0); push(1'b0, 8'hD1); push(1'b0, 8'hD2);
    cyc(1);
    chk("R2 count before loop", q_count, 3);
    loop_en = 1'b1;
    cyc(1);
    chk("R4 head C0", head_data, 8'hC0); popw();
    chk("R5 count frozen", q_count, 3);
    chk("R4 head D1", head_data, 8'hD1); popw();
    chk("R4 head D2", head_data, 8'hD2); popw();
    chk("R5 count frozen drained", q_count, 3);
    chk("R6 no reload while busy", head_valid, 0);
    eng_idle = 1'b1;
    cyc(1);
    chk("R6 reload valid", head_valid, 1);
    chk("R6 reload head", head_data, 8'hC0);
    chk("R5 empty frozen", q_empty, 0);
    eng_idle = 1'b0;

    // R7 fullness against saved position
    popw(); popw();
    push(1'b0, 8'hE3);
    push(1'b0, 8'hE4);
    chk("R7 head D2", head_data, 8'hD2); popw();
    chk("R7 head E3", head_data, 8'hE3); popw();
    chk("R7 drained", head_valid, 0);
    eng_idle = 1'b1;
    cyc(1);
    chk("R7 saved entry intact", head_data, 8'hC0);
    eng_idle = 1'b0;

    // R8 leave loop mode
    loop_en = 1'b0;
    cyc(1);
    chk("R8 count recomputed", q_count, 4);
    chk("R8 full recomputed", q_full, 1);
    popw(); popw();
    cyc(1);
    chk("R8 count consumed", q_count, 2);
    chk("R8 head continues", head_data, 8'hD2);
    popw(); popw();
    eng_idle = 1'b1;
    cyc(2);
    chk("R8 no replay", head_valid, 0);
    chk("R8 count zero", q_count, 0);

    // R9 / R10 frame end
    wd(); chk("R9 8 bits", frame_end, 0);
    wd(); chk("R9 16 bits", frame_end, 0);
    wd(); chk("R9 24 bits", frame_end, 1);
    cyc(1); chk("R9 pulse", frame_end, 0);
    wd(); chk("R9 restart", frame_end, 0);
    push(1'b1, 8'hC5);
    wd(); chk("R10 cmd at head", frame_end, 1);
    popw();
    push(1'b0, 8'h77);
    wd(); chk("R10 total cleared", frame_end, 0);
    wd();
    wd(); chk("R9 full frame again", frame_end, 1);

    // R11 / R12 request gating and start
    hreq_gate = 1'b1;
    cyc(1);
    chk("R12 no request", start_ok, 0);
    hreq = 1'b1;
    cyc(2);
    chk("R11 not sampled while idle", start_ok, 0);
    eng_idle = 1'b0; cyc(1);
    eng_idle = 1'b1; cyc(1);
    cyc(1);
    chk("R11 sampled on idle", start_ok, 1);
    hreq = 1'b0;
    cyc(2);
    chk("R11 latched holds", start_ok, 1);
    blk_en = 1'b0; cyc(1);
    chk("R12 disabled", start_ok, 0);
    blk_en = 1'b1; hreq_gate = 1'b0; cyc(1);
    chk("R12 gate off", start_ok, 1);
    popw();
    cyc(1);
    chk("R12 empty blocks", start_ok, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule